// File: doc/BRIEF.md
# PS/2 Port Register Interface

This block is the bus-facing register file for a single PS/2 keyboard or mouse port. A processor reaches it through a simple 32-bit slave interface that decodes a 4 KB address window. Inside that window are five word registers: control, status, data, clock divisor and interrupt identification. At the top of the window there is also a read-only identification area.

Behind the registers the block talks to a separate line engine at byte level. That engine does the bit-level serialisation on the PS/2 clock and data wires, and it is not part of this block. Received bytes arrive with a one-cycle valid strobe. A byte to be sent leaves with a one-cycle start strobe, and the engine reports back through a busy flag. The block drives one level-sensitive interrupt.

Software uses the port in a simple loop. It enables the receive interrupt, waits for the interrupt line, and reads the data register to take the pending byte. It can check parity on that byte through the status register. To transmit, it writes a byte to the data register while the transmitter is idle.

Top module: `ps2_host_regs`

## Requirements
- R1: The block decodes the 12-bit byte address `bus_addr` only when `bus_addr[1:0]` is 0. The word index `bus_addr[11:2]` selects: 0 control, 1 status, 2 data, 3 clock divisor, 4 interrupt identification. Any other offset, and any offset with nonzero low bits, reads as 0 and ignores writes.
- R2: The control register holds the full 32-bit written value and reads it back. Reset clears it to 0.
- R3: The clock-divisor register holds the full 32-bit written value and reads it back. Reset clears it to 0.
- R4: The status register is read-only. Bits above 6 read 0. The lower bits are:
  - bit 6: transmit empty, which is the inverse of `tx_busy`
  - bit 5: transmit busy, which equals `tx_busy`
  - bit 4: a received byte is pending
  - bit 3: receive busy, which equals `rx_active`
  - bit 2: receive parity
  - bit 1: the sampled clock line `line_clk`
  - bit 0: the sampled data line `line_dat`
- R5: The receive-parity status bit is the XOR of all 8 bits of the last byte returned by a data-register read. After reset it is 0.
- R6: A cycle with `rx_valid` high stores `rx_byte` and sets the pending flag. A new byte that arrives while one is already pending replaces it, and pending stays set. If a data read and `rx_valid` fall in the same cycle, the read takes the older byte and the new byte remains pending. Reset clears pending.
- R7: A data-register read while a byte is pending does three things: it copies that byte into the last-byte register, clears pending, and returns the byte. A data-register read with nothing pending returns the last byte again and changes nothing.
- R8: `irq` is high when control bit 4 is set and a byte is pending, or whenever control bit 3 is set. It follows a control write or a change of pending in the same clock edge that updates them.
- R9: The interrupt-identification register reads the pending flag in bit 0 and a constant 1 in bit 1. All other bits read 0.
- R10: A data-register write while `tx_busy` is low raises `tx_start` for exactly the next cycle and presents the low 8 bits of the write on `tx_byte`. A data-register write while `tx_busy` is high is ignored: no `tx_start`, and `tx_byte` is unchanged.
- R11: Reads at byte offsets 0xFE0 to 0xFFC (one byte per word) return the identification bytes in this order: 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Bits above 7 read 0.
- R12: Read data is registered. `bus_rdata` shows the value of a read in the cycle after the access, and keeps it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_byte | input | 8 | Byte received by the line engine |
| rx_valid | input | 1 | One-cycle strobe: rx_byte is new |
| rx_active | input | 1 | Line engine is receiving a frame |
| line_clk | input | 1 | Sampled PS/2 clock line |
| line_dat | input | 1 | Sampled PS/2 data line |
| tx_byte | output | 8 | Byte to be sent |
| tx_start | output | 1 | One-cycle strobe: start sending tx_byte |
| tx_busy | input | 1 | Line engine is sending |
| irq | output | 1 | Level interrupt |

## Verification
Results are due at different cycles depending on their path:
- **Register reads** appear on `bus_rdata` one cycle after the access. The driver therefore queues each expected read value just after the access edge, and the monitor compares it at the following falling edge.
- **`tx_start` and `tx_byte`** change at the edge that takes a data write.
- **Pending** changes at the edge that takes `rx_valid` or a data read.

`irq` is a combinational function of registered state, so it is valid at the same falling edge as those changes. Direct checks on it, and on the transmit outputs, are made there. The bench checks again one cycle later to confirm that `tx_start` is a single-cycle pulse.

// File: rtl/ps2_regs_pkg.sv
package ps2_regs_pkg;

   localparam int WIN_AW = 12;
   localparam int BYTE_W = 8;

   // Status bit positions
   localparam int ST_TX_EMPTY = 6;
   localparam int ST_TX_BUSY  = 5;
   localparam int ST_RX_FULL  = 4;
   localparam int ST_RX_BUSY  = 3;
   localparam int ST_RX_PAR   = 2;
   localparam int ST_LINE_CLK = 1;
   localparam int ST_LINE_DAT = 0;

   // Control bit positions used by the interrupt logic
   localparam int CT_TX_IE = 3;
   localparam int CT_RX_IE = 4;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_STAT,
      SEL_DATA,
      SEL_CDIV,
      SEL_IRID,
      SEL_IDENT
   } reg_sel_e;

   function automatic logic [BYTE_W-1:0] ident_byte(input logic [2:0] idx);
      logic [BYTE_W-1:0] b;
      case (idx)
         3'd0:    b = 8'h50;
         3'd1:    b = 8'h10;
         3'd2:    b = 8'h04;
         3'd3:    b = 8'h00;
         3'd4:    b = 8'h0D;
         3'd5:    b = 8'hF0;
         3'd6:    b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/ps2_addr_decode.sv
module ps2_addr_decode
   import ps2_regs_pkg::*;
(
   input  logic [WIN_AW-1:0] addr,
   output reg_sel_e          sel,
   output logic [2:0]        id_idx
);
   localparam int WORD_W = WIN_AW - 2;

   logic [WORD_W-1:0] word;
   logic              aligned;
   logic              in_ident;

   assign word     = addr[WIN_AW-1:2];
   assign aligned  = (addr[1:0] == 2'b00);
   // Identification area: the top eight words of the window
   assign in_ident = (addr[WIN_AW-1:5] == '1);
   assign id_idx   = addr[4:2];

   always_comb begin
      sel = SEL_NONE;
      if (aligned) begin
         if (in_ident) begin
            sel = SEL_IDENT;
         end else begin
            case (word)
               WORD_W'(0): sel = SEL_CTRL;
               WORD_W'(1): sel = SEL_STAT;
               WORD_W'(2): sel = SEL_DATA;
               WORD_W'(3): sel = SEL_CDIV;
               WORD_W'(4): sel = SEL_IRID;
               default:    sel = SEL_NONE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ps2_rx_hold.sv
module ps2_rx_hold #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [BW-1:0] rx_byte,
   input  logic          take,
   output logic          pending,
   output logic [BW-1:0] read_val,
   output logic          parity
);
   logic [BW-1:0] hold_q;
   logic [BW-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         last_q  <= '0;
         pending <= 1'b0;
      end else begin
         if (take && pending) begin
            last_q <= hold_q;
         end
         if (rx_valid) begin
            hold_q  <= rx_byte;
            pending <= 1'b1;
         end else if (take) begin
            pending <= 1'b0;
         end
      end
   end

   // Value a data read returns this cycle
   assign read_val = pending ? hold_q : last_q;
   assign parity   = ^last_q;
endmodule

// File: rtl/ps2_tx_launch.sv
module ps2_tx_launch #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_data,
   input  logic [BW-1:0] wbyte,
   input  logic          tx_busy,
   output logic          tx_start,
   output logic [BW-1:0] tx_byte
);
   logic go;

   assign go = wr_data && !tx_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_start <= 1'b0;
         tx_byte  <= '0;
      end else begin
         tx_start <= go;
         if (go) begin
            tx_byte <= wbyte;
         end
      end
   end
endmodule

// File: rtl/ps2_host_regs.sv
module ps2_host_regs
   import ps2_regs_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit HAS_IDENT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [WIN_AW-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [BYTE_W-1:0]  rx_byte,
   input  logic               rx_valid,
   input  logic               rx_active,
   input  logic               line_clk,
   input  logic               line_dat,
   output logic [BYTE_W-1:0]  tx_byte,
   output logic               tx_start,
   input  logic               tx_busy,
   output logic               irq
);
   localparam int ST_W = ST_TX_EMPTY + 1;

   if (DATA_W < 8) begin : g_bad_width
      $error("ps2_host_regs: DATA_W must be at least 8");
   end

   reg_sel_e            sel;
   logic [2:0]          id_idx;
   logic                do_rd;
   logic                do_wr;
   logic [DATA_W-1:0]   ctrl_q;
   logic [DATA_W-1:0]   cdiv_q;
   logic                rx_pending;
   logic [BYTE_W-1:0]   rx_read_val;
   logic                rx_parity;
   logic [ST_W-1:0]     stat;
   logic [BYTE_W-1:0]   ident_val;
   logic [DATA_W-1:0]   rd_val;

   assign do_rd = bus_sel && !bus_wr;
   assign do_wr = bus_sel &&  bus_wr;

   ps2_addr_decode u_dec (
      .addr   (bus_addr),
      .sel    (sel),
      .id_idx (id_idx)
   );

   ps2_rx_hold #(.BW(BYTE_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .take     (do_rd && (sel == SEL_DATA)),
      .pending  (rx_pending),
      .read_val (rx_read_val),
      .parity   (rx_parity)
   );

   ps2_tx_launch #(.BW(BYTE_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_data  (do_wr && (sel == SEL_DATA)),
      .wbyte    (bus_wdata[BYTE_W-1:0]),
      .tx_busy  (tx_busy),
      .tx_start (tx_start),
      .tx_byte  (tx_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cdiv_q <= '0;
      end else if (do_wr) begin
         if (sel == SEL_CTRL) ctrl_q <= bus_wdata;
         if (sel == SEL_CDIV) cdiv_q <= bus_wdata;
      end
   end

   if (HAS_IDENT) begin : g_ident
      assign ident_val = ident_byte(id_idx);
   end else begin : g_no_ident
      assign ident_val = '0;
   end

   always_comb begin
      stat              = '0;
      stat[ST_TX_EMPTY] = !tx_busy;
      stat[ST_TX_BUSY]  = tx_busy;
      stat[ST_RX_FULL]  = rx_pending;
      stat[ST_RX_BUSY]  = rx_active;
      stat[ST_RX_PAR]   = rx_parity;
      stat[ST_LINE_CLK] = line_clk;
      stat[ST_LINE_DAT] = line_dat;
   end

   always_comb begin
      rd_val = '0;
      case (sel)
         SEL_CTRL:  rd_val = ctrl_q;
         SEL_STAT:  rd_val = DATA_W'(stat);
         SEL_DATA:  rd_val = DATA_W'(rx_read_val);
         SEL_CDIV:  rd_val = cdiv_q;
         SEL_IRID:  rd_val = DATA_W'({1'b1, rx_pending});
         SEL_IDENT: rd_val = DATA_W'(ident_val);
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (do_rd) begin
         bus_rdata <= rd_val;
      end
   end

   assign irq = (ctrl_q[CT_RX_IE] && rx_pending) || ctrl_q[CT_TX_IE];

endmodule

// File: rtl/ps2_host_regs_chk.sv
module ps2_host_regs_chk #(
   parameter int BW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_sel,
   input logic          bus_wr,
   input logic [11:0]   bus_addr,
   input logic [BW-1:0] wbyte,
   input logic          rx_valid,
   input logic          tx_busy,
   input logic          tx_start,
   input logic [BW-1:0] tx_byte,
   input logic          pending,
   input logic [1:0]    ctrl_ie,
   input logic          irq
);
   logic data_acc;

   assign data_acc = bus_sel && (bus_addr == 12'h008);

   // R6
   rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> pending);

   // R7
   take_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !bus_wr && pending && !rx_valid) |=> !pending);

   // R10
   tx_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && bus_wr && !tx_busy) |=> (tx_start && tx_byte == $past(wbyte)));

   // R10
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && bus_wr && tx_busy) |=> (!tx_start && $stable(tx_byte)));

   // R8
   irq_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_ie[0] |-> irq);

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_ie[0] && !pending) |-> !irq);
endmodule

bind ps2_host_regs ps2_host_regs_chk #(.BW(ps2_regs_pkg::BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .wbyte    (bus_wdata[ps2_regs_pkg::BYTE_W-1:0]),
   .rx_valid (rx_valid),
   .tx_busy  (tx_busy),
   .tx_start (tx_start),
   .tx_byte  (tx_byte),
   .pending  (rx_pending),
   .ctrl_ie  (ctrl_q[4:3]),
   .irq      (irq)
);

// File: tb/ps2_host_regs_bench.sv
module ps2_host_regs_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  rx_byte = '0;
   logic        rx_valid = 1'b0;
   logic        rx_active = 1'b0;
   logic        line_clk = 1'b0;
   logic        line_dat = 1'b0;
   logic [7:0]  tx_byte;
   logic        tx_start;
   logic        tx_busy = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [31:0] val;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ps2_host_regs u_ps2_host_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rx_byte   (rx_byte),
      .rx_valid  (rx_valid),
      .rx_active (rx_active),
      .line_clk  (line_clk),
      .line_dat  (line_dat),
      .tx_byte   (tx_byte),
      .tx_start  (tx_start),
      .tx_busy   (tx_busy),
      .irq       (irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Monitor: compares registered read data one cycle after each read
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(e.tag, bus_rdata, e.val);
      end
   end

   // All tasks start and end at a falling edge
   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
      exp_t e;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk);
      e.val = exp; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      rx_valid = 1'b1; rx_byte = b;
      @(posedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state: R2 R3 R4 R5 R9
      bus_read(12'h000, 32'h0, "R2 ctrl reset");
      bus_read(12'h00C, 32'h0, "R3 divisor reset");
      bus_read(12'h004, 32'h40, "R4 status reset");
      bus_read(12'h010, 32'h2, "R9 irid reset");
      bus_read(12'h008, 32'h0, "R7 data reset");
      check("R8 irq reset", {31'b0, irq}, 32'h0);

      // R2 R8: receive interrupt enable with nothing pending
      bus_write(12'h000, 32'h0000_0010);
      bus_read(12'h000, 32'h10, "R2 ctrl readback");
      check("R8 irq idle rx enable", {31'b0, irq}, 32'h0);

      // R6 R8 R9 R4: byte arrives
      rx_push(8'hA7);
      check("R8 irq on pending", {31'b0, irq}, 32'h1);
      bus_read(12'h004, 32'h50, "R4 status pending");
      bus_read(12'h010, 32'h3, "R9 irid pending");

      // R7 R5 R12: take the byte; register stays until next read
      bus_read(12'h008, 32'hA7, "R7 data take");
      check("R8 irq after take", {31'b0, irq}, 32'h0);
      @(negedge clk);
      check("R12 rdata held", bus_rdata, 32'hA7);
      bus_read(12'h004, 32'h44, "R5 parity odd byte");
      bus_read(12'h010, 32'h2, "R9 irid cleared");
      bus_read(12'h008, 32'hA7, "R7 data repeat");

      // R6 overwrite
      rx_push(8'h11);
      rx_push(8'h03);
      bus_read(12'h008, 32'h03, "R6 overwrite");
      bus_read(12'h004, 32'h40, "R5 parity even byte");

      // R6 same-cycle arrival and read
      rx_push(8'h5A);
      rx_valid = 1'b1; rx_byte = 8'h66;
      bus_read(12'h008, 32'h5A, "R6 collide old byte");
      rx_valid = 1'b0;
      bus_read(12'h010, 32'h3, "R6 collide still pending");
      bus_read(12'h008, 32'h66, "R6 collide new byte");

      // R8 transmit enable
      bus_write(12'h000, 32'h0000_0008);
      check("R8 irq tx enable", {31'b0, irq}, 32'h1);
      bus_write(12'h000, 32'h0);
      check("R8 irq off", {31'b0, irq}, 32'h0);

      // R10 transmit
      bus_write(12'h008, 32'h0000_01C5);
      check("R10 tx_start", {31'b0, tx_start}, 32'h1);
      check("R10 tx_byte", {24'b0, tx_byte}, 32'hC5);
      @(negedge clk);
      check("R10 tx_start one cycle", {31'b0, tx_start}, 32'h0);
      tx_busy = 1'b1;
      bus_write(12'h008, 32'h33);
      check("R10 busy no start", {31'b0, tx_start}, 32'h0);
      check("R10 busy byte kept", {24'b0, tx_byte}, 32'hC5);
      bus_read(12'h004, 32'h20, "R4 status tx busy");
      tx_busy = 1'b0;

      // R4 receive busy and line bits
      rx_active = 1'b1; line_clk = 1'b1; line_dat = 1'b0;
      bus_read(12'h004, 32'h4A, "R4 status lines");
      rx_active = 1'b0; line_clk = 1'b0; line_dat = 1'b1;
      bus_read(12'h004, 32'h41, "R4 status data line");
      line_dat = 1'b0;

      // R3 divisor
      bus_write(12'h00C, 32'hDEAD_01AB);
      bus_read(12'h00C, 32'hDEAD_01AB, "R3 divisor readback");

      // R11 identification
      bus_read(12'hFE0, 32'h50, "R11 ident 0");
      bus_read(12'hFF0, 32'h0D, "R11 ident 4");
      bus_read(12'hFF4, 32'hF0, "R11 ident 5");
      bus_read(12'hFFC, 32'hB1, "R11 ident 7");

      // R1 undefined and misaligned offsets
      bus_write(12'h000, 32'h0000_0055);
      bus_write(12'h014, 32'hFFFF_FFFF);
      bus_write(12'h001, 32'hFFFF_FFFF);
      bus_read(12'h000, 32'h55, "R1 stray writes ignored");
      bus_read(12'h014, 32'h0, "R1 undefined reads zero");
      bus_read(12'h00D, 32'h0, "R1 misaligned reads zero");
      bus_read(12'h800, 32'h0, "R1 hole reads zero");

      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule